// File: doc/BRIEF.md
# Edge-selectable interrupt controller

This block collects interrupt requests from three sources and decides, at instruction boundaries, whether the instruction sequencer should divert to an interrupt routine and which one. The sources are an asynchronous external pin, a one-cycle match pulse from an 8-bit timer, and a one-cycle tick pulse from an interval timer. Each source has a sticky request flag, and each flag has its own enable. A single global enable gates every acceptance.

The external pin passes through a synchronising chain before its edges are detected. One configuration bit selects whether a rising or a falling transition raises the pin's request. The synchronised pin level is also available on a port, and it does not depend on the request flag. When an enabled request is pending, the global enable is set and the sequencer signals that an instruction has finished, the block pulses `take_o` for one cycle and presents a vector index. In the same edge it clears the chosen request flag and the global enable. A return-from-interrupt strobe sets the global enable again. Software can clear request flags through the write port. A new event that arrives in the same cycle as a clear survives it.

Top module: `irq_ctrl`

## Requirements
- R1: After synchronous reset, `take_o` is 0, all request flags read 0, every per-source enable and the global enable are 0, and the edge select is 0 (rising).
- R2: With edge select 0, a 0-to-1 change on `ext_pin_i` makes `pin_lvl_o` show 1 after the second rising clock edge and sets request bit 0 at the third edge. A 1-to-0 change sets nothing.
- R3: With edge select 1, a 1-to-0 change on `ext_pin_i` sets request bit 0 at the third clock edge. A 0-to-1 change sets nothing.
- R4: Writing the edge select while the pin level is steady never sets request bit 0.
- R5: A one-cycle pulse on `ivt_evt_i` sets request bit 1, and one on `tmr_evt_i` sets request bit 2, at the next clock edge.
- R6: A write to address 2 clears every request flag whose data bit is 0 and leaves flags whose data bit is 1 unchanged. An event for a source in the same cycle as a clear of its flag leaves that flag set.
- R7: `take_o` is high for exactly one cycle, in the cycle after an `insn_end_i` strobe that finds the global enable at 1 and at least one request that is both pending and enabled. Without that strobe, no interrupt is taken however long a request waits.
- R8: Address 0 holds the per-source enables in bits 0 (pin), 1 (interval timer) and 2 (8-bit timer), and the global enable in bit 3. A pending request whose enable is 0 is never taken and stays pending.
- R9: Acceptance clears the chosen request flag and the global enable in the same edge that raises `take_o`. Other pending flags are kept, and a second `insn_end_i` takes nothing until the global enable is restored.
- R10: When several requests are eligible, the pin wins over the interval timer, and the interval timer wins over the 8-bit timer. `vec_o` reads 0, 1 or 2 for those sources.
- R11: A `reti_i` strobe sets the global enable at the next edge, so a later boundary can take any remaining eligible request.
- R12: `pin_lvl_o` follows the synchronised pin level whether the pin's request flag is set or cleared.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| ext_pin_i | input | 1 | Asynchronous external interrupt pin |
| tmr_evt_i | input | 1 | 8-bit timer match pulse |
| ivt_evt_i | input | 1 | Interval timer tick pulse |
| wr_en_i | input | 1 | Configuration write strobe |
| wr_addr_i | input | 2 | Write address: 0 enables, 1 edge select (bit 0), 2 request clear mask |
| wr_data_i | input | 4 | Write data |
| insn_end_i | input | 1 | Instruction-boundary strobe from the sequencer |
| reti_i | input | 1 | Return-from-interrupt strobe |
| take_o | output | 1 | One-cycle pulse that orders the sequencer to vector |
| vec_o | output | 2 | Index of the accepted source, held until the next acceptance |
| req_o | output | 3 | Current request flags |
| pin_lvl_o | output | 1 | Synchronised external pin level |

## Verification
Each result falls due a fixed number of edges after its cause. A pin change appears on `pin_lvl_o` after two edges and in the request flag after three. Timer pulses and writes take effect after one edge. An `insn_end_i` strobe raises `take_o` after one edge, and `take_o` falls again one edge later. The bench drives every input just after a falling clock edge and waits exactly that number of rising edges. It then reads the outputs at the next falling edge, so each check lands in the one cycle where the response is due. A sweep over every combination of pending sources and enable masks compares the taken flag, the vector and the remaining flags with values the bench derives from the masks alone.

// File: rtl/irq_pkg.sv
package irq_pkg;
  // Source order is the priority order: lower index wins.
  localparam int NSRC  = 3;
  localparam int IDX_W = $clog2(NSRC);
  localparam int WD_W  = NSRC + 1;

  localparam int SRC_PIN = 0;
  localparam int SRC_IVT = 1;
  localparam int SRC_TMR = 2;

  typedef enum logic [1:0] {
    A_ENABLE = 2'd0,
    A_EDGE   = 2'd1,
    A_CLRREQ = 2'd2,
    A_SPARE  = 2'd3
  } waddr_e;
endpackage

// File: rtl/irq_pin_sync.sv
module irq_pin_sync #(
  parameter int STAGES = 2
) (
  input  logic clk,
  input  logic rst,
  input  logic pin_i,
  output logic lvl_o,
  output logic rise_o,
  output logic fall_o
);
  logic [STAGES-1:0] chain_q;
  logic              last_q;

  always_ff @(posedge clk) begin
    if (rst) begin
      chain_q <= '0;
      last_q  <= 1'b0;
    end else begin
      chain_q <= {chain_q[STAGES-2:0], pin_i};
      last_q  <= chain_q[STAGES-1];
    end
  end

  assign lvl_o  = chain_q[STAGES-1];
  assign rise_o = chain_q[STAGES-1] & ~last_q;
  assign fall_o = ~chain_q[STAGES-1] & last_q;
endmodule

// File: rtl/irq_flags.sv
module irq_flags #(
  parameter int N = 3
) (
  input  logic         clk,
  input  logic         rst,
  input  logic [N-1:0] set_i,
  input  logic [N-1:0] clr_i,
  input  logic [N-1:0] ack_i,
  output logic [N-1:0] flag_o
);
  logic [N-1:0] flag_q;

  for (genvar g = 0; g < N; g++) begin : g_flag
    always_ff @(posedge clk) begin
      if (rst)
        flag_q[g] <= 1'b0;
      else if (set_i[g])
        flag_q[g] <= 1'b1;
      else if (clr_i[g] || ack_i[g])
        flag_q[g] <= 1'b0;
    end
  end

  assign flag_o = flag_q;
endmodule

// File: rtl/irq_arb.sv
module irq_arb #(
  parameter int N = 3,
  localparam int IW = (N > 1) ? $clog2(N) : 1
) (
  input  logic [N-1:0]  cand_i,
  output logic          any_o,
  output logic [IW-1:0] idx_o,
  output logic [N-1:0]  grant_o
);
  always_comb begin
    idx_o = '0;
    for (int i = N - 1; i >= 0; i--) begin
      if (cand_i[i]) idx_o = IW'(i);
    end
  end

  assign any_o   = |cand_i;
  assign grant_o = any_o ? (N'(1) << idx_o) : '0;
endmodule

// File: rtl/irq_ctrl.sv
module irq_ctrl
  import irq_pkg::*;
#(
  parameter int SYNC_STAGES = 2
) (
  input  logic             clk,
  input  logic             rst,
  input  logic             ext_pin_i,
  input  logic             tmr_evt_i,
  input  logic             ivt_evt_i,
  input  logic             wr_en_i,
  input  logic [1:0]       wr_addr_i,
  input  logic [WD_W-1:0]  wr_data_i,
  input  logic             insn_end_i,
  input  logic             reti_i,
  output logic             take_o,
  output logic [IDX_W-1:0] vec_o,
  output logic [NSRC-1:0]  req_o,
  output logic             pin_lvl_o
);
  logic            edge_sel_q;
  logic            gie_q;
  logic [NSRC-1:0] en_q;
  logic            take_q;
  logic [IDX_W-1:0] vec_q;

  logic            pin_rise, pin_fall;
  logic [NSRC-1:0] set_ev, clr_wr, ack, grant, flags, cand;
  logic            any_cand, accept;
  logic [IDX_W-1:0] win_idx;

  waddr_e wsel;
  assign wsel = waddr_e'(wr_addr_i);

  irq_pin_sync #(.STAGES(SYNC_STAGES)) u_sync (
    .clk    (clk),
    .rst    (rst),
    .pin_i  (ext_pin_i),
    .lvl_o  (pin_lvl_o),
    .rise_o (pin_rise),
    .fall_o (pin_fall)
  );

  always_comb begin
    set_ev          = '0;
    set_ev[SRC_PIN] = edge_sel_q ? pin_fall : pin_rise;
    set_ev[SRC_IVT] = ivt_evt_i;
    set_ev[SRC_TMR] = tmr_evt_i;
  end

  assign clr_wr = (wr_en_i && wsel == A_CLRREQ) ? ~wr_data_i[NSRC-1:0] : '0;
  assign ack    = accept ? grant : '0;

  irq_flags #(.N(NSRC)) u_flags (
    .clk    (clk),
    .rst    (rst),
    .set_i  (set_ev),
    .clr_i  (clr_wr),
    .ack_i  (ack),
    .flag_o (flags)
  );

  assign cand = flags & en_q & {NSRC{gie_q}};

  irq_arb #(.N(NSRC)) u_arb (
    .cand_i  (cand),
    .any_o   (any_cand),
    .idx_o   (win_idx),
    .grant_o (grant)
  );

  assign accept = insn_end_i & any_cand;

  always_ff @(posedge clk) begin
    if (rst) begin
      edge_sel_q <= 1'b0;
      en_q       <= '0;
      gie_q      <= 1'b0;
      take_q     <= 1'b0;
      vec_q      <= '0;
    end else begin
      take_q <= accept;
      if (accept) vec_q <= win_idx;

      if (wr_en_i && wsel == A_EDGE) edge_sel_q <= wr_data_i[0];
      if (wr_en_i && wsel == A_ENABLE) en_q <= wr_data_i[NSRC-1:0];

      if (accept)
        gie_q <= 1'b0;
      else if (reti_i)
        gie_q <= 1'b1;
      else if (wr_en_i && wsel == A_ENABLE)
        gie_q <= wr_data_i[NSRC];
    end
  end

  assign take_o = take_q;
  assign vec_o  = vec_q;
  assign req_o  = flags;
endmodule

// File: rtl/irq_ctrl_chk.sv
module irq_ctrl_chk
  import irq_pkg::*;
(
  input logic             clk,
  input logic             rst,
  input logic             insn_end_i,
  input logic             take_o,
  input logic [IDX_W-1:0] vec_o,
  input logic [NSRC-1:0]  req_o,
  input logic             pin_lvl_o,
  input logic             gie_q
);
  AST_TAKE_AT_BOUNDARY: assert property (@(posedge clk) disable iff (rst)
    take_o |-> $past(insn_end_i)); // R7

  AST_TAKE_ONE_CYCLE: assert property (@(posedge clk) disable iff (rst)
    take_o |=> !take_o); // R7

  AST_GIE_DROPS_ON_TAKE: assert property (@(posedge clk) disable iff (rst)
    take_o |-> !gie_q); // R9

  AST_VEC_IN_RANGE: assert property (@(posedge clk) disable iff (rst)
    take_o |-> (vec_o < IDX_W'(NSRC))); // R10

  AST_PIN_REQ_NEEDS_EDGE: assert property (@(posedge clk) disable iff (rst)
    $rose(req_o[SRC_PIN]) |-> ($past(pin_lvl_o) != $past(pin_lvl_o, 2))); // R4
endmodule

bind irq_ctrl irq_ctrl_chk u_chk (
  .clk        (clk),
  .rst        (rst),
  .insn_end_i (insn_end_i),
  .take_o     (take_o),
  .vec_o      (vec_o),
  .req_o      (req_o),
  .pin_lvl_o  (pin_lvl_o),
  .gie_q      (gie_q)
);

// File: tb/irq_ctrl_tb.sv
module irq_ctrl_tb;
  logic       clk = 1'b0;
  logic       rst = 1'b1;
  logic       ext_pin_i = 1'b0, tmr_evt_i = 1'b0, ivt_evt_i = 1'b0;
  logic       wr_en_i = 1'b0;
  logic [1:0] wr_addr_i = '0;
  logic [3:0] wr_data_i = '0;
  logic       insn_end_i = 1'b0, reti_i = 1'b0;
  logic       take_o, pin_lvl_o;
  logic [1:0] vec_o;
  logic [2:0] req_o;

  int total = 0;
  int bad   = 0;
  bit done  = 0;

  always #2 clk = ~clk;

  irq_ctrl u_dut (
    .clk(clk), .rst(rst), .ext_pin_i(ext_pin_i), .tmr_evt_i(tmr_evt_i),
    .ivt_evt_i(ivt_evt_i), .wr_en_i(wr_en_i), .wr_addr_i(wr_addr_i),
    .wr_data_i(wr_data_i), .insn_end_i(insn_end_i), .reti_i(reti_i),
    .take_o(take_o), .vec_o(vec_o), .req_o(req_o), .pin_lvl_o(pin_lvl_o)
  );

  task automatic check(input int act, input int exp, input string tag);
    total++;
    if (act != exp) begin
      bad++;
      $display("FAIL %s: actual=%0d expected=%0d", tag, act, exp);
    end
  endtask

  task automatic tick(input int n = 1);
    for (int i = 0; i < n; i++) @(negedge clk);
  endtask

  task automatic wr(input logic [1:0] a, input logic [3:0] d);
    wr_en_i = 1'b1; wr_addr_i = a; wr_data_i = d;
    tick();
    wr_en_i = 1'b0;
  endtask

  task automatic pulse_insn();
    insn_end_i = 1'b1; tick(); insn_end_i = 1'b0;
  endtask

  task automatic pulse_reti();
    reti_i = 1'b1; tick(); reti_i = 1'b0;
  endtask

  // Toggle the pin with the edge select chosen so the toggle counts (R2/R3).
  task automatic make_pin_req();
    wr(2'd1, {3'b000, ext_pin_i});
    ext_pin_i = ~ext_pin_i;
    tick(2);
    check(pin_lvl_o, ext_pin_i, "R12 level after two edges");
    tick();
  endtask

  function automatic int low_bit(input int m);
    for (int i = 0; i < 3; i++) if (m[i]) return i;
    return 0;
  endfunction

  initial begin
    tick(3);
    rst = 1'b0;
    tick();
    check(take_o, 0, "R1 take after reset");
    check(req_o, 0, "R1 flags after reset");
    check(pin_lvl_o, 0, "R1 pin level after reset");
    tmr_evt_i = 1'b1; tick(); tmr_evt_i = 1'b0;
    pulse_insn();
    check(take_o, 0, "R1 enables off after reset");
    check(req_o, 3'b100, "R5 timer flag set");

    // Rising pin with select 0 sets; falling does not (R2).
    wr(2'd2, 4'h0);
    ext_pin_i = 1'b1; tick(2);
    check(req_o[0], 0, "R2 flag not before third edge");
    tick();
    check(req_o[0], 1, "R2 rising sets with select 0");
    wr(2'd2, 4'h0);
    ext_pin_i = 1'b0; tick(4);
    check(req_o[0], 0, "R2 falling ignored with select 0");

    // Falling pin with select 1 sets; rising does not (R3).
    wr(2'd1, 4'h1);
    ext_pin_i = 1'b1; tick(4);
    check(req_o[0], 0, "R3 rising ignored with select 1");
    ext_pin_i = 1'b0; tick(3);
    check(req_o[0], 1, "R3 falling sets with select 1");

    // Toggling the select with a steady pin (R4).
    wr(2'd2, 4'h0);
    ext_pin_i = 1'b1; tick(4);
    wr(2'd2, 4'h0);
    wr(2'd1, 4'h0); wr(2'd1, 4'h1); wr(2'd1, 4'h0); tick(3);
    check(req_o[0], 0, "R4 select change with pin high");
    check(pin_lvl_o, 1, "R12 level with flag clear");

    // Clear mask and set-wins (R6).
    ivt_evt_i = 1'b1; tmr_evt_i = 1'b1; tick();
    ivt_evt_i = 1'b0; tmr_evt_i = 1'b0;
    wr(2'd2, 4'b0101);
    check(req_o, 3'b100, "R6 clear only zero bits");
    tmr_evt_i = 1'b1; wr(2'd2, 4'h0); tmr_evt_i = 1'b0;
    check(req_o, 3'b100, "R6 event wins over clear");

    // No boundary, no take (R7).
    wr(2'd0, 4'b1100);
    tick(6);
    check(take_o, 0, "R7 no take without boundary");
    check(req_o, 3'b100, "R7 flag stays pending");
    wr(2'd0, 4'h0);
    ext_pin_i = 1'b0; tick(4);

    // Sweep of pending sets against enable masks (R8-R11).
    for (int p = 0; p < 8; p++) begin
      for (int e = 0; e < 8; e++) begin
        int rem;
        int elig;
        wr(2'd0, 4'(e));
        wr(2'd2, 4'h0);
        if (p[0]) make_pin_req();
        if (p[1]) begin ivt_evt_i = 1'b1; tick(); ivt_evt_i = 1'b0; end
        if (p[2]) begin tmr_evt_i = 1'b1; tick(); tmr_evt_i = 1'b0; end
        check(req_o, p, "R5 pending pattern");
        wr(2'd0, 4'(8 + e));
        pulse_insn();
        elig = p & e;
        check(take_o, elig != 0, "R8 take versus enables");
        if (elig != 0) begin
          check(vec_o, low_bit(elig), "R10 priority vector");
          rem = p & ~(1 << low_bit(elig));
          check(req_o, rem, "R9 chosen flag cleared");
        end else begin
          check(req_o, p, "R8 disabled stays pending");
        end
        tick();
        check(take_o, 0, "R7 single-cycle take");
        if (elig != 0) begin
          pulse_insn();
          check(take_o, 0, "R9 global enable cleared");
          pulse_reti();
          pulse_insn();
          check(take_o, (rem & e) != 0, "R11 take after return");
          if ((rem & e) != 0)
            check(vec_o, low_bit(rem & e), "R11 next vector");
          tick();
        end
      end
    end
    done = 1;
    $display("test done: total=%0d bad=%0d", total, bad);
    $finish;
  end

  initial begin
    repeat (20000) @(posedge clk);
    if (!done) begin
      total++;
      bad++;
      $display("FAIL watchdog: actual=hung expected=finished");
      $display("test done: total=%0d bad=%0d", total, bad);
      $finish;
    end
  end
endmodule